// File: doc/BRIEF.md
# Three-Pair Complementary Dead-Time Inserter

This block sits between a PWM generator and the gate drivers of a three-phase bridge. It receives one command bit per phase and turns each bit into a complementary pair of active-high gate signals. Command 1 selects the pair's first output and command 0 selects its second output. Whenever a pair switches sides, the output that is leaving drops at once. The output that is arriving waits a programmed number of clock cycles before it rises, which leaves a gap in which neither switch conducts.

The gap can differ for each switching direction. One count sets the wait before a first output rises. The other count sets the wait before a second output rises. All three pairs share both counts, and each pair runs its own down-counter, so the phases switch independently. Counts are defined only for even values: bit 0 of each count is ignored. If a command reverses while a pair is still waiting, the pending rise is dropped and the wait starts over for the new side. When the enable is low, all six outputs are held low.

Top module: `dtp_three_pair`

## Requirements
- R1: While reset is asserted, and on every cycle after reset until the enable is first sampled high, all six gate outputs are low.
- R2: When `en` is sampled low at a rising clock edge, all six gate outputs are low after that edge, whatever the commands do.
- R3: When an enabled pair's command changes, the output that was active goes low at the first rising edge that samples the new command.
- R4: On a change of command from 0 to 1, `gate_first` rises NA clock edges after the edge at which `gate_second` fell. NA is `dt_first` with bit 0 cleared.
- R5: On a change of command from 1 to 0, `gate_second` rises NB clock edges after the edge at which `gate_first` fell. NB is `dt_second` with bit 0 cleared.
- R6: Bit 0 of `dt_first` and of `dt_second` has no effect, so an odd count behaves like the next lower even count.
- R7: When the applicable effective count is zero, the departing output falls and the arriving output rises at the same clock edge.
- R8: If a pair's command reverses before the arriving output has risen, that rise is cancelled. The wait then restarts, counted from the edge that samples the reversal, using the count for the new direction.
- R9: The two outputs of a pair are never high in the same cycle.
- R10: Each pair switches only on its own command bit. A change on one pair leaves the outputs of the other pairs unchanged.
- R11: When `en` is first sampled high, the output selected by each command rises after the count for its direction, counted from that edge. A zero count makes it rise at that same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock; one dead-time count equals one period |
| rst_n | input | 1 | Asynchronous active-low reset; it is released through a synchronizer |
| en | input | 1 | Output enable; when low, all gates are forced low |
| phase_cmd | input | NPAIR (3) | Per-pair command: 1 selects the first output, 0 selects the second |
| dt_first | input | DT_W (10) | Dead-time count before a first output rises; bit 0 is ignored |
| dt_second | input | DT_W (10) | Dead-time count before a second output rises; bit 0 is ignored |
| gate_first | output | NPAIR (3) | First output of each pair, active high |
| gate_second | output | NPAIR (3) | Second output of each pair, active high |

## Verification
The embedded properties check on every cycle that the two outputs of a pair never overlap and that disabling blanks every gate. They also check that a departing output drops at the edge after a change, that a zero count passes a change straight through, and that a pair's counter never holds a value above the largest even count. The length of each gap is checked only by the bench's scenarios, which measure it edge by edge for both directions, for odd counts and for the full-range count. The bench scenarios also cover the restart after a reversal in mid-gap, the isolation between pairs and the start-up timing after the enable rises.

// File: rtl/dtp_pkg.sv
package dtp_pkg;

  // Side of a pair that the command currently selects.
  typedef enum logic {
    SIDE_SECOND = 1'b0,
    SIDE_FIRST  = 1'b1
  } side_e;

endpackage

// File: rtl/dtp_rst_sync.sv
// Reset synchronizer: the reset asserts asynchronously and is released on a clock edge.
module dtp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/dtp_even.sv
// Clears the least significant bit of a count, so that only even counts reach the lanes.
module dtp_even #(
  parameter int W = 10
) (
  input  logic [W-1:0] raw,
  output logic [W-1:0] even
);

  generate
    if (W > 1) begin : g_wide
      assign even = {raw[W-1:1], 1'b0};
    end else begin : g_narrow
      assign even = '0;
    end
  endgenerate

endmodule

// File: rtl/dtp_en_track.sv
// Flags the first enabled cycle, so that the lanes can start a gap there.
module dtp_en_track (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic start
);

  logic en_q;
  logic en_d;

  always_comb begin
    en_d = en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= en_d;
  end

  assign start = en & ~en_q;

  // R11: the start flag lasts exactly one cycle.
  p_start_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !start);

endmodule

// File: rtl/dtp_lane.sv
// One complementary pair: it tracks the target side, counts the gap and drives both gates.
module dtp_lane #(
  parameter int DT_W = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            start,
  input  logic            cmd,
  input  logic [DT_W-1:0] dly_first,
  input  logic [DT_W-1:0] dly_second,
  output logic            gate_first,
  output logic            gate_second
);
  import dtp_pkg::*;

  localparam logic [DT_W-1:0] CNT_ONE  = {{(DT_W-1){1'b0}}, 1'b1};
  localparam logic [DT_W-1:0] CNT_ZERO = '0;

  side_e           tgt_q, tgt_d;
  logic [DT_W-1:0] cnt_q, cnt_d;
  logic            gf_q, gf_d;
  logic            gs_q, gs_d;
  logic            changed;
  logic            load;
  logic [DT_W-1:0] load_val;

  // Next-state logic.
  always_comb begin
    changed  = (side_e'(cmd) != tgt_q);
    load     = en && (changed || start);
    load_val = cmd ? dly_first : dly_second;
    tgt_d    = tgt_q;
    cnt_d    = cnt_q;
    if (!en) begin
      tgt_d = side_e'(cmd);
      cnt_d = CNT_ZERO;
    end else if (load) begin
      tgt_d = side_e'(cmd);
      cnt_d = load_val;
    end else if (cnt_q != CNT_ZERO) begin
      cnt_d = cnt_q - CNT_ONE;
    end
    gf_d = en && (tgt_d == SIDE_FIRST)  && (cnt_d == CNT_ZERO);
    gs_d = en && (tgt_d == SIDE_SECOND) && (cnt_d == CNT_ZERO);
  end

  // State registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q <= SIDE_SECOND;
      cnt_q <= CNT_ZERO;
      gf_q  <= 1'b0;
      gs_q  <= 1'b0;
    end else begin
      tgt_q <= tgt_d;
      cnt_q <= cnt_d;
      gf_q  <= gf_d;
      gs_q  <= gs_d;
    end
  end

  assign gate_first  = gf_q;
  assign gate_second = gs_q;

  // R9: the two gates of a pair never overlap.
  p_no_overlap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_first && gate_second));

  // R2: a low enable blanks the pair at the next edge.
  p_blank_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!gate_first && !gate_second));

  // R3: a departing gate falls at the edge that samples the new command.
  p_depart_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && gate_first && !cmd) |=> !gate_first);
  p_depart_second_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && gate_second && cmd) |=> !gate_second);

  // R7: a zero count passes a change through in one edge.
  p_zero_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (side_e'(cmd) != tgt_q) && ((cmd ? dly_first : dly_second) == CNT_ZERO))
      |=> ($past(cmd) ? gate_first : gate_second));

  // R6: an even count never loads an odd value, so the counter never exceeds the largest even count.
  p_cnt_even_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(&cnt_q));

endmodule

// File: rtl/dtp_three_pair.sv
module dtp_three_pair #(
  parameter int NPAIR = 3,
  parameter int DT_W  = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [NPAIR-1:0] phase_cmd,
  input  logic [DT_W-1:0]  dt_first,
  input  logic [DT_W-1:0]  dt_second,
  output logic [NPAIR-1:0] gate_first,
  output logic [NPAIR-1:0] gate_second
);

  localparam int SYNC_STAGES = 2;

  logic            rst_int_n;
  logic            start;
  logic [DT_W-1:0] eff_first;
  logic [DT_W-1:0] eff_second;

  dtp_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  dtp_even #(.W(DT_W)) u_even_first (
    .raw  (dt_first),
    .even (eff_first)
  );

  dtp_even #(.W(DT_W)) u_even_second (
    .raw  (dt_second),
    .even (eff_second)
  );

  dtp_en_track u_en (
    .clk   (clk),
    .rst_n (rst_int_n),
    .en    (en),
    .start (start)
  );

  generate
    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
      dtp_lane #(.DT_W(DT_W)) u_lane (
        .clk         (clk),
        .rst_n       (rst_int_n),
        .en          (en),
        .start       (start),
        .cmd         (phase_cmd[p]),
        .dly_first   (eff_first),
        .dly_second  (eff_second),
        .gate_first  (gate_first[p]),
        .gate_second (gate_second[p])
      );
    end
  endgenerate

endmodule

// File: tb/dtp_three_pair_test.sv
module dtp_three_pair_test;

  localparam int CLK_PERIOD = 10;
  localparam int NPAIR = 3;
  localparam int DT_W  = 10;
  localparam int NVEC  = 7;

  typedef struct packed {
    logic            to_first;
    logic [DT_W-1:0] da;
    logic [DT_W-1:0] db;
    logic [31:0]     gap;
  } vec_t;

  // Each row gives the direction of the change, the two raw counts and the expected gap (the even count).
  localparam vec_t VECS [NVEC] = '{
    '{to_first:1'b1, da:10'd4,    db:10'd6, gap:32'd4},
    '{to_first:1'b0, da:10'd4,    db:10'd6, gap:32'd6},
    '{to_first:1'b1, da:10'd7,    db:10'd2, gap:32'd6},
    '{to_first:1'b0, da:10'd7,    db:10'd3, gap:32'd2},
    '{to_first:1'b1, da:10'd0,    db:10'd8, gap:32'd0},
    '{to_first:1'b0, da:10'd5,    db:10'd1, gap:32'd0},
    '{to_first:1'b1, da:10'd1023, db:10'd0, gap:32'd1022}
  };

  logic             clk;
  logic             rst_n;
  logic             en;
  logic [NPAIR-1:0] phase_cmd;
  logic [DT_W-1:0]  dt_first;
  logic [DT_W-1:0]  dt_second;
  logic [NPAIR-1:0] gate_first;
  logic [NPAIR-1:0] gate_second;

  int nchk = 0;
  int nerr = 0;

  dtp_three_pair #(.NPAIR(NPAIR), .DT_W(DT_W)) uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .en          (en),
    .phase_cmd   (phase_cmd),
    .dt_first    (dt_first),
    .dt_second   (dt_second),
    .gate_first  (gate_first),
    .gate_second (gate_second)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t v);
    int n;
    bit up;
    string tag;
    dt_first  = v.da;
    dt_second = v.db;
    phase_cmd = {NPAIR{~v.to_first}};
    repeat (1030) tick();
    chk((v.to_first ? gate_second : gate_first) == {NPAIR{1'b1}}, "R4/R5 settle",
        int'(v.to_first ? gate_second : gate_first), 7);
    phase_cmd = {NPAIR{v.to_first}};
    n  = 0;
    up = 1'b0;
    while (!up && n < 1100) begin
      tick();
      n++;
      if (n == 1)
        chk((v.to_first ? gate_second : gate_first) == '0, "R3 departing drop",
            int'(v.to_first ? gate_second : gate_first), 0);
      if ((gate_first & gate_second) != '0)
        chk(1'b0, "R9 overlap", int'(gate_first & gate_second), 0);
      up = ((v.to_first ? gate_first : gate_second) == {NPAIR{1'b1}});
    end
    tag = v.to_first ? "R4" : "R5";
    if (v.da[0] || v.db[0]) tag = {tag, " R6"};
    if (v.gap == 0) tag = {tag, " R7"};
    chk(n == int'(v.gap) + 1, tag, n, int'(v.gap) + 1);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    nchk++;
    nerr++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin : main
    int n;
    bit seen;
    rst_n     = 1'b0;
    en        = 1'b0;
    phase_cmd = '0;
    dt_first  = '0;
    dt_second = '0;
    repeat (3) tick();
    chk(gate_first == '0 && gate_second == '0, "R1 in reset",
        int'({gate_first, gate_second}), 0);
    rst_n = 1'b1;
    repeat (5) tick();
    chk(gate_first == '0 && gate_second == '0, "R1 after reset",
        int'({gate_first, gate_second}), 0);

    // R11: start-up after the enable rises, count 4 toward the first outputs.
    phase_cmd = '1;
    dt_first  = 10'd4;
    dt_second = 10'd2;
    tick();
    en = 1'b1;
    n = 0;
    seen = 1'b0;
    while (gate_first != '1 && n < 50) begin
      tick();
      n++;
      if (gate_second != '0) seen = 1'b1;
    end
    chk(n == 5, "R11 startup gap", n, 5);
    chk(!seen, "R11 second side quiet", int'(seen), 0);

    // Table of vectors: gap length for each direction and count.
    for (int i = 0; i < NVEC; i++) run_vec(VECS[i]);

    // R8: a reversal in mid-gap restarts the wait for the new side.
    dt_first  = 10'd6;
    dt_second = 10'd6;
    phase_cmd = '0;
    repeat (20) tick();
    phase_cmd = '1;
    repeat (3) tick();
    chk(gate_first == '0 && gate_second == '0, "R8 both low in gap",
        int'({gate_first, gate_second}), 0);
    phase_cmd = '0;
    n = 0;
    seen = 1'b0;
    while (gate_second != '1 && n < 50) begin
      tick();
      n++;
      if (gate_first != '0) seen = 1'b1;
    end
    chk(n == 7, "R8 restarted gap", n, 7);
    chk(!seen, "R8 cancelled rise", int'(seen), 0);

    // R10: pair 1 switches alone.
    dt_first  = 10'd2;
    dt_second = 10'd2;
    phase_cmd = 3'b000;
    repeat (20) tick();
    phase_cmd = 3'b010;
    tick();
    chk(gate_second == 3'b101 && gate_first == 3'b000, "R10 others hold",
        int'({gate_first, gate_second}), 5);
    repeat (2) tick();
    chk(gate_first == 3'b010 && gate_second == 3'b101, "R10 pair 1 switched",
        int'({gate_first, gate_second}), 21);

    // R2: disable blanks everything, even when the commands change.
    en = 1'b0;
    tick();
    chk(gate_first == '0 && gate_second == '0, "R2 blank",
        int'({gate_first, gate_second}), 0);
    phase_cmd = 3'b101;
    repeat (4) tick();
    chk(gate_first == '0 && gate_second == '0, "R2 blank with change",
        int'({gate_first, gate_second}), 0);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule